// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves data words from memory to memory, or between a fixed peripheral address and a memory buffer. It does this on behalf of up to four requesting peripherals, without the processor copying each word. Software gives each channel a source address, a destination address, a word count and a control word. A channel becomes eligible once it is enabled, its count is nonzero and its peripheral raises its request line.

When some channel is eligible and the system bus is not busy, the controller asks the processor for the bus through a hold/grant handshake. It then serves the lowest-numbered eligible channel and signals that peripheral on its active-low acknowledge line. Each word is a read at the source followed by a write of the captured data at the destination. Each address either steps by one or stays fixed, as set for the channel.

A channel in burst tenure keeps the bus from word to word. A channel in single-cycle tenure hands the bus back after every word. When the count runs out, the channel disables itself and records a done flag, and it can raise the interrupt line.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, hold_req is low, every dack_n bit is high, irq is low, mem_rd and mem_wr are low, and the status register reads 0.
- R2: hold_req rises only when bus_busy was low at the preceding clock edge. While bus_busy stays high, no request is made.
- R3: mem_rd and mem_wr are asserted only while both hold_req and hold_gnt are high.
- R4: Among the eligible channels (control bit 0 set, request high, count nonzero), the one with the lowest index is served first. The choice is made when leaving idle and is kept for the whole tenure.
- R5: Each word is a mem_rd cycle at the current source address, followed two cycles later by a mem_wr cycle at the current destination that carries the data read. The serving channel's dack_n bit is low from the read through the write, and at most one dack_n bit is low at any time.
- R6: With control bit 1 set, the source address increases by one after each word; with it clear, the source address is held. Control bit 2 does the same for the destination address.
- R7: A length of N moves exactly N words. Register offset 4c+2 reads the remaining count of channel c, which drops by one per word.
- R8: With control bit 3 set (burst), hold_req stays high and the next read follows the write directly, as long as words remain and the channel's request is high. If the request is low when a write completes, the bus is released.
- R9: With control bit 3 clear (single-cycle), hold_req drops for at least one cycle after every word, and a block of N words makes N separate requests.
- R10: When the last word completes, control bit 0 clears and bit c of the status register (offset 0x20) sets. irq is high while any set status bit belongs to a channel whose control bit 4 is set. Writing 1 to a status bit clears it.
- R11: Channel c has its registers at offset 4c+k: k=0 source address, k=1 destination address, k=2 length/count, k=3 control. Writes load a register, and reads return its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dreq | input | 4 | Per-channel service requests from peripherals |
| dack_n | output | 4 | Per-channel acknowledge and transfer strobe, active low |
| bus_busy | input | 1 | High while another master is using the bus |
| hold_req | output | 1 | Bus request to the processor |
| hold_gnt | input | 1 | Bus grant from the processor |
| mem_rd | output | 1 | Memory read strobe; data returns the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after mem_rd |
| irq | output | 1 | Block-complete interrupt |

## Verification
The assertions assume that the processor keeps hold_gnt high for as long as hold_req stays high once it has granted. They also assume that memory returns read data exactly one cycle after mem_rd, and that software does not rewrite a channel's registers while that channel is being served. The bench models the grant as hold_req delayed by one register, so it never withdraws a grant early. Its memory model answers reads with a fixed one-cycle latency. It programs each channel only while that channel's request is low or its transfer has finished. Request lines change only on falling clock edges, including the deliberate withdrawal in the middle of a burst.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int N_CH   = 4;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 16;
  localparam int RA_W   = 6;
  localparam int CH_W   = $clog2(N_CH);

  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RD, ST_LAT, ST_WR} eng_st_t;

  // control word, bit 0 is en
  typedef struct packed {
    logic irq_en;
    logic burst;
    logic dst_inc;
    logic src_inc;
    logic en;
  } ch_ctrl_t;

  localparam int CTRL_W = $bits(ch_ctrl_t);

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a, input logic inc);
    return inc ? a + ADDR_W'(1) : a;
  endfunction

  function automatic logic [LEN_W-1:0] count_down(input logic [LEN_W-1:0] c);
    return c - LEN_W'(1);
  endfunction

  // lowest set index wins
  function automatic logic [CH_W-1:0] pick_first(input logic [N_CH-1:0] req);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (req[i]) idx = CH_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_done,
  input  logic              step,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [LEN_W-1:0]  cnt_q,
  output ch_ctrl_t          ctrl_q,
  output logic              done_q
);
  logic last_word;
  assign last_word = (cnt_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (clr_done) done_q <= 1'b0;
      if (wr_en) begin
        case (wr_sel)
          2'd0:    src_q  <= wdata[ADDR_W-1:0];
          2'd1:    dst_q  <= wdata[ADDR_W-1:0];
          2'd2:    cnt_q  <= wdata[LEN_W-1:0];
          default: ctrl_q <= ch_ctrl_t'(wdata[CTRL_W-1:0]);
        endcase
      end
      if (step) begin
        src_q <= advance(src_q, ctrl_q.src_inc);
        dst_q <= advance(dst_q, ctrl_q.dst_inc);
        cnt_q <= count_down(cnt_q);
        if (last_word) begin
          ctrl_q.en <= 1'b0;
          done_q    <= 1'b1;
        end
      end
    end
  end

  assert_step_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cnt_q != '0);
  assert_count_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en) |=> cnt_q == $past(cnt_q) - LEN_W'(1));
  assert_src_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && !ctrl_q.src_inc) |=> $stable(src_q));
  assert_dst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && !ctrl_q.dst_inc) |=> $stable(dst_q));
  assert_block_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_word && !wr_en) |=> (!ctrl_q.en && done_q));
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   elig,
  input  logic [N_CH-1:0]   dreq,
  input  logic              bus_busy,
  input  logic              hold_gnt,
  input  logic              cur_burst,
  input  logic              cur_last,
  input  logic [ADDR_W-1:0] cur_src,
  input  logic [ADDR_W-1:0] cur_dst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CH_W-1:0]   cur_ch,
  output logic              hold_req,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [N_CH-1:0]   dack_n,
  output logic              word_done
);
  eng_st_t           state;
  logic [DATA_W-1:0] data_q;
  logic              in_xfer;
  logic              keep_bus;
  logic              start_req;

  assign start_req = (|elig) && !bus_busy;
  assign keep_bus  = !cur_last && cur_burst && dreq[cur_ch];
  assign in_xfer   = (state == ST_RD) || (state == ST_LAT) || (state == ST_WR);
  assign hold_req  = (state != ST_IDLE);
  assign mem_rd    = (state == ST_RD);
  assign mem_wr    = (state == ST_WR);
  assign word_done = mem_wr;
  assign mem_addr  = mem_wr ? cur_dst : cur_src;
  assign mem_wdata = data_q;

  always_comb begin
    dack_n = '1;
    if (in_xfer) dack_n[cur_ch] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cur_ch <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_req) begin
          state  <= ST_REQ;
          cur_ch <= pick_first(elig);
        end
        ST_REQ:  if (hold_gnt) state <= ST_RD;
        ST_RD:   state <= ST_LAT;
        ST_LAT: begin
          data_q <= mem_rdata;
          state  <= ST_WR;
        end
        ST_WR:   state <= keep_bus ? ST_RD : ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_bus_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> $past(!bus_busy));
  assert_drive_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (hold_req && hold_gnt));
  assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ##2 mem_wr);
  assert_write_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ##1 mem_wdata == $past(mem_rdata));
  assert_burst_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && keep_bus) |=> (hold_req && mem_rd));
  assert_single_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cur_burst) |=> !hold_req);
  assert_one_dack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_CH-1:0]   dreq,
  output logic [N_CH-1:0]   dack_n,
  input  logic              bus_busy,
  output logic              hold_req,
  input  logic              hold_gnt,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq
);
  logic [ADDR_W-1:0] src_a [N_CH];
  logic [ADDR_W-1:0] dst_a [N_CH];
  logic [LEN_W-1:0]  cnt_a [N_CH];
  ch_ctrl_t          ctrl_a [N_CH];
  logic [N_CH-1:0]   done_vec;
  logic [N_CH-1:0]   ie_vec;
  logic [N_CH-1:0]   elig;
  logic [CH_W-1:0]   cur_ch;
  logic [CH_W-1:0]   reg_ch;
  logic              word_done;
  logic              status_sel;

  assign status_sel = (reg_addr[RA_W-1:CH_W+2] != '0);
  assign reg_ch     = reg_addr[CH_W+1:2];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dma4_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we && !status_sel && reg_ch == CH_W'(g)),
      .wr_sel   (reg_addr[1:0]),
      .wdata    (reg_wdata),
      .clr_done (reg_we && status_sel && reg_wdata[g]),
      .step     (word_done && cur_ch == CH_W'(g)),
      .src_q    (src_a[g]),
      .dst_q    (dst_a[g]),
      .cnt_q    (cnt_a[g]),
      .ctrl_q   (ctrl_a[g]),
      .done_q   (done_vec[g])
    );
    assign elig[g]   = ctrl_a[g].en && dreq[g] && (cnt_a[g] != '0);
    assign ie_vec[g] = ctrl_a[g].irq_en;
  end

  dma4_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .elig      (elig),
    .dreq      (dreq),
    .bus_busy  (bus_busy),
    .hold_gnt  (hold_gnt),
    .cur_burst (ctrl_a[cur_ch].burst),
    .cur_last  (cnt_a[cur_ch] == LEN_W'(1)),
    .cur_src   (src_a[cur_ch]),
    .cur_dst   (dst_a[cur_ch]),
    .mem_rdata (mem_rdata),
    .cur_ch    (cur_ch),
    .hold_req  (hold_req),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .dack_n    (dack_n),
    .word_done (word_done)
  );

  assign irq = |(done_vec & ie_vec);

  always_comb begin
    reg_rdata = '0;
    if (status_sel) reg_rdata[N_CH-1:0] = done_vec;
    else begin
      case (reg_addr[1:0])
        2'd0:    reg_rdata = DATA_W'(src_a[reg_ch]);
        2'd1:    reg_rdata = DATA_W'(dst_a[reg_ch]);
        2'd2:    reg_rdata = DATA_W'(cnt_a[reg_ch]);
        default: reg_rdata = DATA_W'(ctrl_a[reg_ch]);
      endcase
    end
  end

  assert_irq_has_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|done_vec));
  assert_served_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ctrl_a[cur_ch].en);
endmodule

// File: tb/sim_dma4_ctrl.sv
`timescale 1ns/1ps
module sim_dma4_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack_n;
  logic        bus_busy = 1'b0;
  logic        hold_req;
  logic        hold_gnt = 1'b0;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        irq;

  always #10 clk = ~clk;

  dma4_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack_n(dack_n),
    .bus_busy(bus_busy), .hold_req(hold_req), .hold_gnt(hold_gnt), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq));

  int checks = 0;
  int fails = 0;
  int hold_rises = 0;
  logic [31:0] mem [256];
  logic [65:0] sb [$];

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {8'h5A, 8'h00, a, a ^ 8'h3C};
  endfunction

  // memory and processor model: one-cycle read, grant follows request
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    hold_gnt <= hold_req;
  end

  always @(posedge hold_req) hold_rises++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_words(input int ch, input logic [31:0] s, input bit sinc,
                              input logic [31:0] d, input bit dinc, input int n);
    for (int i = 0; i < n; i++) begin
      sb.push_back({ch[1:0], d, pat(s[7:0])});
      if (sinc) s = s + 1;
      if (dinc) d = d + 1;
    end
  endtask

  // monitor side
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (sb.size() == 0) chk(1'b0, "R7 extra write", {32'h0, mem_addr}, 64'h0);
      else begin
        logic [65:0] it;
        it = sb.pop_front();
        chk(mem_addr == it[63:32] && mem_wdata == it[31:0] &&
            dack_n == ~(4'b0001 << it[65:64]), "R4 R5 R6 write",
            {mem_addr, mem_wdata}, it[63:0]);
      end
    end
  end

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic program_ch(input int ch, input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] n, input logic [4:0] ctl);
    reg_write(6'(ch * 4 + 0), s);
    reg_write(6'(ch * 4 + 1), d);
    reg_write(6'(ch * 4 + 2), {16'h0, n});
    reg_write(6'(ch * 4 + 3), {27'h0, ctl});
  endtask

  task automatic wait_done(input int ch);
    logic [31:0] st;
    for (int i = 0; i < 3000; i++) begin
      reg_read(6'h20, st);
      if (st[ch]) return;
    end
    chk(1'b0, "R10 done timeout", 64'h0, 64'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r0;
    for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hold_req == 1'b0, "R1 hold_req", {63'h0, hold_req}, 64'h0);
    chk(dack_n == 4'hF, "R1 dack_n", {60'h0, dack_n}, 64'hF);
    chk(irq == 1'b0 && !mem_rd && !mem_wr, "R1 irq/strobes", {61'h0, irq, mem_rd, mem_wr}, 64'h0);
    reg_read(6'h20, v);
    chk(v == 0, "R1 status", {32'h0, v}, 64'h0);

    // burst, both addresses step, interrupt on
    expect_words(0, 32'h10, 1, 32'h40, 1, 4);
    r0 = hold_rises;
    program_ch(0, 32'h10, 32'h40, 16'd4, 5'b11111);
    dreq[0] = 1'b1;
    wait_done(0);
    dreq[0] = 1'b0;
    chk(hold_rises - r0 == 1, "R8 one tenure", 64'(hold_rises - r0), 64'd1);
    chk(irq == 1'b1, "R10 irq set", {63'h0, irq}, 64'h1);
    reg_read(6'h03, v);
    chk(v[0] == 1'b0, "R10 enable cleared", {32'h0, v}, 64'h1E);
    reg_read(6'h02, v);
    chk(v == 0, "R7 count zero", {32'h0, v}, 64'h0);
    reg_read(6'h00, v);
    chk(v == 32'h14, "R6 source stepped", {32'h0, v}, 64'h14);
    reg_write(6'h20, 32'h1);
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq cleared", {63'h0, irq}, 64'h0);
    reg_read(6'h20, v);
    chk(v == 0, "R10 status cleared", {32'h0, v}, 64'h0);

    // single-cycle, source held, no interrupt
    expect_words(2, 32'h80, 0, 32'h60, 1, 3);
    r0 = hold_rises;
    program_ch(2, 32'h80, 32'h60, 16'd3, 5'b00101);
    dreq[2] = 1'b1;
    wait_done(2);
    dreq[2] = 1'b0;
    chk(hold_rises - r0 == 3, "R9 tenure per word", 64'(hold_rises - r0), 64'd3);
    chk(irq == 1'b0, "R10 irq masked", {63'h0, irq}, 64'h0);
    reg_read(6'h08, v);
    chk(v == 32'h80, "R6 source held", {32'h0, v}, 64'h80);
    reg_read(6'h09, v);
    chk(v == 32'h63, "R6 destination stepped", {32'h0, v}, 64'h63);
    reg_write(6'h20, 32'h4);

    // priority: channels 1 and 3 request together
    expect_words(1, 32'h30, 1, 32'h50, 1, 2);
    expect_words(3, 32'h38, 1, 32'h70, 0, 2);
    program_ch(3, 32'h38, 32'h70, 16'd2, 5'b00011);
    program_ch(1, 32'h30, 32'h50, 16'd2, 5'b01111);
    reg_read(6'h0C, v);
    chk(v == 32'h38, "R11 source readback", {32'h0, v}, 64'h38);
    reg_read(6'h0E, v);
    chk(v == 32'h2, "R11 length readback", {32'h0, v}, 64'h2);
    @(negedge clk);
    dreq = 4'b1010;
    wait_done(3);
    dreq = 4'b0000;
    reg_read(6'h20, v);
    chk(v == 32'hA, "R4 both done", {32'h0, v}, 64'hA);
    chk(mem[8'h70] == pat(8'h39), "R6 destination held", {32'h0, mem[8'h70]}, {32'h0, pat(8'h39)});
    reg_write(6'h20, 32'hA);

    // bus busy holds off the request
    bus_busy = 1'b1;
    expect_words(2, 32'h84, 1, 32'hA0, 1, 1);
    program_ch(2, 32'h84, 32'hA0, 16'd1, 5'b10111);
    dreq[2] = 1'b1;
    repeat (10) @(negedge clk);
    chk(hold_req == 1'b0 && !mem_rd, "R2 no request while busy", {62'h0, hold_req, mem_rd}, 64'h0);
    bus_busy = 1'b0;
    wait_done(2);
    dreq[2] = 1'b0;
    reg_write(6'h20, 32'h4);

    // burst withdrawn after first word
    expect_words(0, 32'h20, 1, 32'h90, 1, 4);
    program_ch(0, 32'h20, 32'h90, 16'd4, 5'b01111);
    dreq[0] = 1'b1;
    @(negedge clk);
    while (!mem_wr) @(negedge clk);
    dreq[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk(hold_req == 1'b0, "R8 released on withdraw", {63'h0, hold_req}, 64'h0);
    reg_read(6'h02, v);
    chk(v == 3, "R7 R8 count after one word", {32'h0, v}, 64'h3);
    dreq[0] = 1'b1;
    wait_done(0);
    dreq[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R7 all words written", 64'(sb.size()), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule